// File: doc/BRIEF.md
# ISA Bus Cycle Sequencer

This block converts host access requests into bus cycles on a legacy expansion bus. Each request names an address, memory or I/O space, read or write direction, and byte or word width. The sequencer drives the address, a single command strobe and the write data. It counts bus clocks so that every kind of cycle lasts the number of clocks its address space, access width and device width call for.

Two inputs are sampled when a request is accepted. One chooses between an 8-bit bus and a 16-bit bus. The other says whether the target device can take 16-bit transfers. A word access that cannot travel as one 16-bit transfer is split into two byte cycles. The low byte moves first, at the request address, and the high byte follows at the next address. A zero-wait-state input from the device cuts a cycle down to its shortest form. A ready input held low stretches it, one clock at a time, until a fixed limit is reached.

Every cycle has a command phase, during which one strobe is active, and then a single recovery clock with no strobe. The cycle lengths quoted below count both phases.

Top module: `isa_cycle_seq`

## Requirements
- R1: `req_ready` is high exactly when the block is idle, including straight after reset. `rsp_done` is a one-clock pulse in the recovery clock of the final cycle, the clock right after the last strobe drops. `req_ready` is high again in the following clock.
- R2: With `wide_bus`=0, a memory byte access lasts 4 clocks: 3 strobe clocks and 1 recovery clock.
- R3: With `wide_bus`=0, an I/O byte access lasts 5 clocks: 4 strobe clocks and 1 recovery clock.
- R4: With `wide_bus`=1 and `dev16`=1, a word access at an even address is one 3-clock cycle (2 strobe clocks and 1 recovery). It carries all 16 data bits on `bus_dout` or `bus_din`.
- R5: With `wide_bus`=1, a byte access to a device with `dev16`=0 lasts 6 clocks. A byte access to a device with `dev16`=1 lasts 3 clocks.
- R6: A word access is split into two byte cycles in two cases: when `wide_bus`=0, and when `dev16`=0. The first cycle goes to the request address and moves the low byte. The second goes to the address plus one, so A0 is set for an even request, and moves the high byte. With `wide_bus`=1 and `dev16`=0 the pair lasts 12 clocks. With `wide_bus`=0 it lasts 8 clocks for memory and 10 clocks for I/O.
- R7: A word access at an odd address to a device with `dev16`=1 on the 16-bit bus is split as in R6 into two 3-clock byte cycles, 6 clocks in total.
- R8: While `bus_zws` is high, the command phase ends after its second strobe clock, so the cycle lasts 3 clocks.
- R9: Once the nominal strobe length has been reached, each clock in which `bus_rdy` is low adds one strobe clock. After `WAIT_MAX` added clocks (default 7), the cycle ends whatever `bus_rdy` says.
- R10: At most one strobe is active at any time. The strobe is `bus_memr`, `bus_memw`, `bus_ior` or `bus_iow`, chosen by space and direction. `bus_addr` holds steady across the strobe and recovery clocks of each byte cycle.
- R11: Byte cycles use data lane bits [7:0] in both directions. The read byte of the first cycle lands in `rsp_rdata[7:0]` with [15:8] cleared, and the second cycle fills `rsp_rdata[15:8]`. `bus_oe` is high throughout every write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Block idle, request accepted when valid |
| req_addr | input | ADDR_W | Request address |
| req_io | input | 1 | 1 = I/O space, 0 = memory space |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 16-bit access, 0 = byte access |
| req_wdata | input | 16 | Write data, low byte in [7:0] |
| wide_bus | input | 1 | 1 = 16-bit bus timing, 0 = 8-bit bus timing |
| dev16 | input | 1 | Target device accepts 16-bit transfers |
| rsp_done | output | 1 | Access complete pulse |
| rsp_rdata | output | 16 | Read data, valid with rsp_done |
| bus_addr | output | ADDR_W | Bus address |
| bus_memr | output | 1 | Memory read strobe, active high |
| bus_memw | output | 1 | Memory write strobe, active high |
| bus_ior | output | 1 | I/O read strobe, active high |
| bus_iow | output | 1 | I/O write strobe, active high |
| bus_dout | output | 16 | Write data driven to the bus |
| bus_oe | output | 1 | Write data drive enable |
| bus_din | input | 16 | Read data from the bus |
| bus_zws | input | 1 | Device requests zero wait states |
| bus_rdy | input | 1 | Device ready, low inserts wait clocks |

## Verification
Requests sweep bus mode, device width, address space, direction, access width and address parity. Each measured cycle length therefore pins down one branch of the length choice: 3, 4, 5, 6, 8, 10 or 12 clocks. Read data comes from a responder whose low byte depends on A0, which shows the order of the byte halves in split words and which lane each byte came from. Zero-wait runs on 5-clock and 6-clock cycles show that the shortcut beats the nominal length. A ready line released after a set number of clocks, and one that is never released, separate per-clock stretching from the timeout.

// File: rtl/isa_cycle_seq.sv
module isa_cycle_seq #(
  parameter int ADDR_W   = 20,
  parameter int WAIT_MAX = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_io,
  input  logic              req_write,
  input  logic              req_word,
  input  logic [15:0]       req_wdata,
  input  logic              wide_bus,
  input  logic              dev16,
  output logic              rsp_done,
  output logic [15:0]       rsp_rdata,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_memr,
  output logic              bus_memw,
  output logic              bus_ior,
  output logic              bus_iow,
  output logic [15:0]       bus_dout,
  output logic              bus_oe,
  input  logic [15:0]       bus_din,
  input  logic              bus_zws,
  input  logic              bus_rdy
);
  localparam int WW = $clog2(WAIT_MAX + 1);

  typedef enum logic [1:0] {S_IDLE, S_CMD, S_REC} st_t;

  st_t               st;
  logic [ADDR_W-1:0] a;
  logic              io, wr, word, wide, d16, part;
  logic [15:0]       wdat, rdat;
  logic [2:0]        cnt, cmd_len;
  logic [WW-1:0]     waits;
  logic              split, full16, nom, fin, last;

  assign split  = word && (!wide || !d16 || a[0]);
  assign full16 = word && !split;
  assign last   = !split || part;

  always_comb begin
    if (!wide)             cmd_len = io ? 3'd4 : 3'd3;
    else if (full16 || d16) cmd_len = 3'd2;
    else                   cmd_len = 3'd5;
  end

  assign nom = cnt >= cmd_len;
  assign fin = (bus_zws && cnt >= 3'd2) || (nom && (bus_rdy || waits == WW'(WAIT_MAX)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; a <= '0; io <= 1'b0; wr <= 1'b0; word <= 1'b0;
      wide <= 1'b0; d16 <= 1'b0; part <= 1'b0; wdat <= '0; rdat <= '0;
      cnt <= '0; waits <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          a <= req_addr; io <= req_io; wr <= req_write; word <= req_word;
          wdat <= req_wdata; wide <= wide_bus; d16 <= dev16;
          part <= 1'b0; cnt <= 3'd1; waits <= '0; st <= S_CMD;
        end
        S_CMD: if (fin) begin
          st <= S_REC;
          if (!wr) begin
            if (full16)    rdat <= bus_din;
            else if (part) rdat[15:8] <= bus_din[7:0];
            else           rdat <= {8'h00, bus_din[7:0]};
          end
        end else if (!nom) cnt <= cnt + 3'd1;
        else               waits <= waits + 1'b1;
        S_REC: if (!last) begin
          part <= 1'b1; cnt <= 3'd1; waits <= '0; st <= S_CMD;
        end else st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign req_ready = st == S_IDLE;
  assign rsp_done  = st == S_REC && last;
  assign rsp_rdata = rdat;
  assign bus_addr  = (st == S_IDLE) ? '0 : a + ADDR_W'(part);
  assign bus_memr  = st == S_CMD && !io && !wr;
  assign bus_memw  = st == S_CMD && !io &&  wr;
  assign bus_ior   = st == S_CMD &&  io && !wr;
  assign bus_iow   = st == S_CMD &&  io &&  wr;
  assign bus_oe    = wr && st != S_IDLE;
  assign bus_dout  = full16 ? wdat : {8'h00, part ? wdat[15:8] : wdat[7:0]};

  logic any_strobe;
  assign any_strobe = bus_memr | bus_memw | bus_ior | bus_iow;

  p_one_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({bus_memr, bus_memw, bus_ior, bus_iow}));

  p_addr_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE && $past(st) != S_IDLE && part == $past(part)) |-> $stable(bus_addr));

  p_done_after_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> (!any_strobe && $past(any_strobe)));

  p_done_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> (!rsp_done && req_ready));

  p_zws_short_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CMD && cnt >= 3'd2 && bus_zws) |=> !any_strobe);

  p_wait_timeout_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CMD && nom && waits == WW'(WAIT_MAX)) |=> !any_strobe);
endmodule

// File: tb/tb_isa_cycle_seq.sv
module tb_isa_cycle_seq;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req_valid = 1'b0, req_io = 1'b0, req_write = 1'b0, req_word = 1'b0;
  logic [19:0] req_addr = '0;
  logic [15:0] req_wdata = '0, bus_din = '0;
  logic        wide_bus = 1'b0, dev16 = 1'b0, bus_zws = 1'b0, bus_rdy = 1'b1;
  logic        req_ready, rsp_done, bus_memr, bus_memw, bus_ior, bus_iow, bus_oe;
  logic [15:0] rsp_rdata, bus_dout;
  logic [19:0] bus_addr;

  always #(CLK_PERIOD/2) clk = ~clk;

  isa_cycle_seq dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_io(req_io), .req_write(req_write), .req_word(req_word),
    .req_wdata(req_wdata), .wide_bus(wide_bus), .dev16(dev16), .rsp_done(rsp_done),
    .rsp_rdata(rsp_rdata), .bus_addr(bus_addr), .bus_memr(bus_memr), .bus_memw(bus_memw),
    .bus_ior(bus_ior), .bus_iow(bus_iow), .bus_dout(bus_dout), .bus_oe(bus_oe),
    .bus_din(bus_din), .bus_zws(bus_zws), .bus_rdy(bus_rdy));

  typedef struct packed {
    logic [3:0]  rq;
    logic        wide, d16, io, wr, word;
    logic [19:0] addr;
    logic [15:0] wdata;
    logic        zws;
    logic [7:0]  hold;
    logic [7:0]  len;
    logic [1:0]  parts;
    logic [15:0] rdat;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VEC [NV] = '{
    '{4'd2, 1'b0,1'b0,1'b0,1'b0,1'b0, 20'h00010, 16'h0000, 1'b0, 8'd0,   8'd4,  2'd1, 16'h00A1}, // R2 mem read
    '{4'd2, 1'b0,1'b0,1'b0,1'b1,1'b0, 20'h00011, 16'h005A, 1'b0, 8'd0,   8'd4,  2'd1, 16'h0000}, // R2 mem write
    '{4'd3, 1'b0,1'b0,1'b1,1'b0,1'b0, 20'h00379, 16'h0000, 1'b0, 8'd0,   8'd5,  2'd1, 16'h00B2}, // R3 io read
    '{4'd3, 1'b0,1'b0,1'b1,1'b1,1'b0, 20'h00378, 16'h00E7, 1'b0, 8'd0,   8'd5,  2'd1, 16'h0000}, // R3 io write
    '{4'd4, 1'b1,1'b1,1'b0,1'b0,1'b1, 20'h10000, 16'h0000, 1'b0, 8'd0,   8'd3,  2'd1, 16'hC3A1}, // R4 word read
    '{4'd4, 1'b1,1'b1,1'b1,1'b1,1'b1, 20'h00300, 16'h1234, 1'b0, 8'd0,   8'd3,  2'd1, 16'h0000}, // R4 word write
    '{4'd5, 1'b1,1'b0,1'b0,1'b0,1'b0, 20'h0C000, 16'h0000, 1'b0, 8'd0,   8'd6,  2'd1, 16'h00A1}, // R5 byte dev
    '{4'd5, 1'b1,1'b1,1'b1,1'b1,1'b0, 20'h00301, 16'h0099, 1'b0, 8'd0,   8'd3,  2'd1, 16'h0000}, // R5 word dev
    '{4'd6, 1'b1,1'b0,1'b0,1'b0,1'b1, 20'h0C020, 16'h0000, 1'b0, 8'd0,   8'd12, 2'd2, 16'hB2A1}, // R6 16-bit bus
    '{4'd6, 1'b0,1'b0,1'b0,1'b0,1'b1, 20'h00040, 16'h0000, 1'b0, 8'd0,   8'd8,  2'd2, 16'hB2A1}, // R6 8-bit mem
    '{4'd6, 1'b0,1'b0,1'b1,1'b1,1'b1, 20'h00300, 16'hBEEF, 1'b0, 8'd0,   8'd10, 2'd2, 16'h0000}, // R6 8-bit io
    '{4'd7, 1'b1,1'b1,1'b0,1'b0,1'b1, 20'h10021, 16'h0000, 1'b0, 8'd0,   8'd6,  2'd2, 16'hA1B2}, // R7 odd word
    '{4'd8, 1'b0,1'b0,1'b1,1'b0,1'b0, 20'h00379, 16'h0000, 1'b1, 8'd0,   8'd3,  2'd1, 16'h00B2}, // R8 io zws
    '{4'd8, 1'b1,1'b0,1'b0,1'b1,1'b0, 20'h0C002, 16'h0077, 1'b1, 8'd0,   8'd3,  2'd1, 16'h0000}, // R8 byte dev zws
    '{4'd9, 1'b0,1'b0,1'b0,1'b0,1'b0, 20'h00010, 16'h0000, 1'b0, 8'd5,   8'd7,  2'd1, 16'h00A1}, // R9 three waits
    '{4'd9, 1'b0,1'b0,1'b0,1'b0,1'b0, 20'h00010, 16'h0000, 1'b0, 8'd255, 8'd11, 2'd1, 16'h00A1}, // R9 timeout
    '{4'd6, 1'b1,1'b0,1'b0,1'b1,1'b1, 20'h0C010, 16'hCAFE, 1'b0, 8'd0,   8'd12, 2'd2, 16'h0000}  // R6 split write
  };

  int nchk = 0, nfail = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input int r, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL R%0d %s: actual %0h expected %0h", r, what, act, exp);
    end
  endtask

  task automatic run(input vec_t v);
    int len = 0, parts = 0, sc = 0;
    bit prev = 1'b0, kind_ok = 1'b1, addr_ok = 1'b1, wd_ok = 1'b1, got = 1'b0;
    logic [3:0]  ek;
    logic [15:0] ew, rd = '0;
    bit f16;
    ek  = {!v.io && !v.wr, !v.io && v.wr, v.io && !v.wr, v.io && v.wr};
    f16 = v.word && v.wide && v.d16 && !v.addr[0];
    @(negedge clk);
    wide_bus = v.wide; dev16 = v.d16; req_io = v.io; req_write = v.wr;
    req_word = v.word; req_addr = v.addr; req_wdata = v.wdata;
    bus_zws = v.zws; bus_rdy = 1'b1; req_valid = 1'b1;
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      req_valid = 1'b0;
      len++;
      if (bus_memr | bus_memw | bus_ior | bus_iow) begin
        sc++;
        if (!prev) parts++;
        if ({bus_memr, bus_memw, bus_ior, bus_iow} != ek) kind_ok = 1'b0;
        if (bus_addr != v.addr + 20'(parts - 1)) addr_ok = 1'b0;
        if (v.wr) begin
          ew = f16 ? v.wdata : {8'h00, (parts == 2) ? v.wdata[15:8] : v.wdata[7:0]};
          if (!bus_oe || bus_dout != ew) wd_ok = 1'b0;
        end
        prev = 1'b1;
      end else prev = 1'b0;
      if (rsp_done) begin rd = rsp_rdata; got = 1'b1; break; end
      bus_din = {8'hC3, bus_addr[0] ? 8'hB2 : 8'hA1};
      bus_rdy = (v.hold == 8'd0) || (sc > int'(v.hold));
    end
    chk(got && len == int'(v.len), v.rq, "cycle length", len, v.len);
    chk(parts == int'(v.parts), v.rq, "byte cycle count", parts, v.parts);
    chk(kind_ok && addr_ok, 10, "strobe kind / address", {kind_ok, addr_ok}, 2'b11); // R10
    if (v.wr) chk(wd_ok, 11, "write lane / oe", wd_ok, 1'b1);                        // R11
    else      chk(rd == v.rdat, v.rq, "read data", rd, v.rdat);
    @(negedge clk);
    chk(!rsp_done && req_ready, 1, "done pulse / ready", {rsp_done, req_ready}, 2'b01); // R1
    bus_zws = 1'b0; bus_rdy = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(req_ready && !rsp_done && !bus_oe && !(bus_memr|bus_memw|bus_ior|bus_iow), 1,
        "reset state", {req_ready, rsp_done, bus_oe}, 3'b100);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready, 1, "idle ready", req_ready, 1'b1);
    for (int k = 0; k < NV; k++) run(VEC[k]);
    // R11: byte read at even address on 16-bit device uses low lane, upper cleared
    run('{4'd11, 1'b1,1'b1,1'b0,1'b0,1'b0, 20'h10002, 16'h0000, 1'b0, 8'd0, 8'd3, 2'd1, 16'h00A1});
    // R1: back-to-back requests each complete
    run(VEC[0]);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL R1 watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule